// File: doc/BRIEF.md
# Four-Channel Match Timer

This block is a memory-mapped system timer. A single up-counter advances by one on every clock cycle in which an external prescaler strobes `tick_en`. Four match registers are compared against the value the counter takes on each tick. When a channel's match value is reached and that channel is enabled, the block latches an event for the channel and drives the channel's interrupt line high. The line stays high until software clears the event.

Channel 3 also serves as a watchdog. If the watchdog arm bit is set when channel 3 matches, the block issues a single-cycle reset request and disarms itself.

Software reaches every register through a simple synchronous bus. Writes take effect on the clock edge on which `bus_wr` is sampled high. Read data is combinational from `bus_addr` while `bus_rd` is high.

Top module: `os_match_timer`

## Requirements
- R1: After reset every register reads zero, `irq_o` is all low and `reset_req_o` is low.
- R2: The counter (read at byte offset 0x10, zero-extended from CNT_W bits) increases by one on each edge where `tick_en` is high. It wraps modulo 2^CNT_W and holds its value when `tick_en` is low.
- R3: A write to offset 0x10 loads the counter, and the following ticks continue from the loaded value. When a load and a tick fall in the same cycle, the load wins. A load never records a match event.
- R4: Channel n matches when a tick moves the counter onto the value in match register n. If interrupt enable bit n is set, status bit n and `irq_o[n]` go high on that same edge and stay high until cleared.
- R5: A match on a channel whose enable bit is clear leaves that channel's status bit and interrupt line unchanged.
- R6: The status register at offset 0x14 (bit n = channel n) is write-one-to-clear. A write clears only the bits written as 1 that are currently set, and other bits are untouched. A match that arrives in the same cycle as its clear keeps the bit set.
- R7: The interrupt enable register at offset 0x1C stores bits 11:0 of a write and reads back bits 31:12 as zero. Bit n enables channel n.
- R8: Watchdog arm is bit 0 of offset 0x18. A channel-3 match while armed produces a one-cycle `reset_req_o` pulse on the match edge and clears the arm bit. This happens whatever the interrupt enables hold. No further pulse occurs until software re-arms the watchdog.
- R9: Match register n sits at offset 4*n and holds CNT_W bits. It may be rewritten while the counter runs, and the new value governs every later tick.
- R10: Reads of unmapped or misaligned offsets return zero. Writes to them change no register.
- R11: `bus_rdata` is zero whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count strobe from the prescaler |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| irq_o | output | NUM_CH | Per-channel interrupt lines |
| reset_req_o | output | 1 | One-cycle watchdog reset request |

## Verification
The bench builds the block with an 8-bit counter and the default four channels. This shrinks the count space to 256 values, so one sweep visits every counter value, crosses the wrap to zero and passes every match value. Full sweeps run twice under different enable masks, and a third sweep runs after the watchdog has fired. Together they show that events are gated, that the counter wraps, and that the watchdog fires exactly once per arming.

// File: rtl/osmt_pkg.sv
package osmt_pkg;
   localparam int BUS_W   = 32;
   // word indices (byte offset / 4) of the shared registers
   localparam int IDX_CNT = 4;
   localparam int IDX_STS = 5;
   localparam int IDX_WDG = 6;
   localparam int IDX_IEN = 7;

   typedef struct packed {
      logic cnt;
      logic sts;
      logic wdg;
      logic ien;
   } osmt_sel_t;
endpackage

// File: rtl/osmt_counter.sv
module osmt_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cnt_nxt_o,
   output logic             step_o
);
   logic [CNT_W-1:0] cnt_q;

   assign cnt_nxt_o = cnt_q + CNT_W'(1);
   assign step_o    = tick_i & ~load_i;
   assign cnt_o     = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (load_i) cnt_q <= load_val_i;
      else if (tick_i) cnt_q <= cnt_nxt_o;
   end

   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i && !load_i |=> (cnt_q - $past(cnt_q)) == CNT_W'(1));
   // R2
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i && !load_i |=> $stable(cnt_q));
   // R3
   cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> cnt_q == $past(load_val_i));
endmodule

// File: rtl/osmt_channel.sv
module osmt_channel #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic [CNT_W-1:0] cnt_nxt_i,
   input  logic             mwe_i,
   input  logic [CNT_W-1:0] mdata_i,
   input  logic             en_i,
   input  logic             clr_i,
   output logic [CNT_W-1:0] mval_o,
   output logic             hit_o,
   output logic             evt_o
);
   logic [CNT_W-1:0] mval_q;
   logic             evt_q;
   logic             set;

   assign hit_o  = step_i && (cnt_nxt_i == mval_q);
   assign set    = hit_o & en_i;
   assign mval_o = mval_q;
   assign evt_o  = evt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mval_q <= '0;
         evt_q  <= 1'b0;
      end else begin
         if (mwe_i) mval_q <= mdata_i;
         evt_q <= set | (evt_q & ~clr_i);
      end
   end

   // R4
   evt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt_q) |-> $past(hit_o && en_i));
   // R5
   evt_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_q && !en_i |=> !evt_q);
   // R6
   evt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_q && clr_i && !(hit_o && en_i) |=> !evt_q);
endmodule

// File: rtl/osmt_watchdog.sv
module osmt_watchdog (
   input  logic clk,
   input  logic rst_n,
   input  logic hit_i,
   input  logic arm_we_i,
   input  logic arm_wdata_i,
   output logic arm_o,
   output logic req_o
);
   logic arm_q, req_q;

   assign arm_o = arm_q;
   assign req_o = req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q <= 1'b0;
         req_q <= 1'b0;
      end else if (hit_i && arm_q) begin
         arm_q <= 1'b0;
         req_q <= 1'b1;
      end else begin
         req_q <= 1'b0;
         if (arm_we_i) arm_q <= arm_wdata_i;
      end
   end

   // R8
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |=> !req_q);
   // R8
   req_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |-> !arm_q && $past(arm_q));
endmodule

// File: rtl/os_match_timer.sv
module os_match_timer
   import osmt_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int NUM_CH  = 4,
   parameter int EN_W    = 12,
   parameter int ADDR_W  = 8,
   parameter int WDOG_CH = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [NUM_CH-1:0] irq_o,
   output logic              reset_req_o
);
   localparam int IDX_W = ADDR_W - 2;

   if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_cnt
      $error("CNT_W must lie in 2..32");
   end
   if (NUM_CH < 1 || NUM_CH > 4) begin : g_bad_ch
      $error("NUM_CH must lie in 1..4");
   end
   if (EN_W < NUM_CH || EN_W > BUS_W) begin : g_bad_en
      $error("EN_W must cover every channel and fit the bus");
   end
   if (WDOG_CH < 0 || WDOG_CH >= NUM_CH) begin : g_bad_wd
      $error("WDOG_CH must name an existing channel");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W too small for the register window");
   end

   logic [IDX_W-1:0]  idx;
   logic              aligned;
   osmt_sel_t         wsel;
   logic [NUM_CH-1:0] mwe, hit_vec, evt_vec, clr_vec;
   logic [CNT_W-1:0]  mval [NUM_CH];
   logic [CNT_W-1:0]  cnt, cnt_nxt;
   logic              step;
   logic [EN_W-1:0]   ien_q;
   logic              wd_arm;

   assign idx     = bus_addr[ADDR_W-1:2];
   assign aligned = (bus_addr[1:0] == 2'b00);

   always_comb begin
      wsel.cnt = bus_wr && aligned && (idx == IDX_W'(IDX_CNT));
      wsel.sts = bus_wr && aligned && (idx == IDX_W'(IDX_STS));
      wsel.wdg = bus_wr && aligned && (idx == IDX_W'(IDX_WDG));
      wsel.ien = bus_wr && aligned && (idx == IDX_W'(IDX_IEN));
   end

   assign clr_vec = wsel.sts ? bus_wdata[NUM_CH-1:0] : '0;

   osmt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_en),
      .load_i     (wsel.cnt),
      .load_val_i (bus_wdata[CNT_W-1:0]),
      .cnt_o      (cnt),
      .cnt_nxt_o  (cnt_nxt),
      .step_o     (step)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      assign mwe[g] = bus_wr && aligned && (idx == IDX_W'(g));
      osmt_channel #(.CNT_W(CNT_W)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .step_i    (step),
         .cnt_nxt_i (cnt_nxt),
         .mwe_i     (mwe[g]),
         .mdata_i   (bus_wdata[CNT_W-1:0]),
         .en_i      (ien_q[g]),
         .clr_i     (clr_vec[g]),
         .mval_o    (mval[g]),
         .hit_o     (hit_vec[g]),
         .evt_o     (evt_vec[g])
      );
   end

   osmt_watchdog u_wd (
      .clk         (clk),
      .rst_n       (rst_n),
      .hit_i       (hit_vec[WDOG_CH]),
      .arm_we_i    (wsel.wdg),
      .arm_wdata_i (bus_wdata[0]),
      .arm_o       (wd_arm),
      .req_o       (reset_req_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ien_q <= '0;
      else if (wsel.ien) ien_q <= bus_wdata[EN_W-1:0];
   end

   assign irq_o = evt_vec;

   always_comb begin
      bus_rdata = '0;
      if (bus_rd && aligned) begin
         for (int k = 0; k < NUM_CH; k++)
            if (idx == IDX_W'(k)) bus_rdata = BUS_W'(mval[k]);
         if (idx == IDX_W'(IDX_CNT)) bus_rdata = BUS_W'(cnt);
         if (idx == IDX_W'(IDX_STS)) bus_rdata = BUS_W'(evt_vec);
         if (idx == IDX_W'(IDX_WDG)) bus_rdata = BUS_W'(wd_arm);
         if (idx == IDX_W'(IDX_IEN)) bus_rdata = BUS_W'(ien_q);
      end
   end

   // R11
   rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> bus_rdata == '0);
   // R7
   ien_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wsel.ien |=> $stable(ien_q));
endmodule

// File: tb/os_match_timer_bench.sv
module os_match_timer_bench;
   localparam int CW = 8;
   localparam int NC = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_en = 1'b0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NC-1:0] irq_o;
   logic          reset_req_o;

   os_match_timer #(.CNT_W(CW)) u_os_match_timer (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_o(irq_o), .reset_req_o(reset_req_o)
   );

   always #10 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [CW-1:0] m_cnt;
   logic [CW-1:0] m_mat [NC];
   logic [NC-1:0] m_evt;
   logic [11:0]   m_ien;
   logic          m_wd;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
      bus_rd = 1'b1; bus_addr = a;
      #1;
      chk(req, bus_rdata, exp);
      bus_rd = 1'b0;
   endtask

   task automatic chk_all(input string req);
      for (int n = 0; n < NC; n++) rd_chk(8'(4 * n), 32'(m_mat[n]), req);
      rd_chk(8'h10, 32'(m_cnt), req);
      rd_chk(8'h14, 32'(m_evt), req);
      rd_chk(8'h18, 32'(m_wd), req);
      rd_chk(8'h1C, 32'(m_ien), req);
      chk(req, 32'(irq_o), 32'(m_evt));
   endtask

   task automatic tick1(input string req);
      logic [CW-1:0] nxt;
      logic [NC-1:0] hit;
      logic          pulse;
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
      nxt = m_cnt + 1'b1;
      for (int n = 0; n < NC; n++) hit[n] = (nxt == m_mat[n]);
      pulse = hit[3] & m_wd;
      if (pulse) m_wd = 1'b0;
      m_evt = m_evt | (hit & m_ien[NC-1:0]);
      m_cnt = nxt;
      chk({req, " irq"}, 32'(irq_o), 32'(m_evt));
      chk("R8 pulse", 32'(reset_req_o), 32'(pulse));
      rd_chk(8'h10, 32'(m_cnt), {req, " R2 count"});
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog timeout actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      m_cnt = '0; m_evt = '0; m_ien = '0; m_wd = 1'b0;
      for (int n = 0; n < NC; n++) m_mat[n] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk_all("R1");
      chk("R1 req", 32'(reset_req_o), 32'd0);

      // R7 enable register keeps 12 bits
      wr(8'h1C, 32'hFFFF_FFFF); m_ien = 12'hFFF;
      rd_chk(8'h1C, 32'h0000_0FFF, "R7");

      // R9 load match values, R4 full sweep with wrap
      wr(8'h00, 32'h05); m_mat[0] = 8'h05;
      wr(8'h04, 32'h80); m_mat[1] = 8'h80;
      wr(8'h08, 32'hFF); m_mat[2] = 8'hFF;
      wr(8'h0C, 32'h00); m_mat[3] = 8'h00;
      chk_all("R9");
      for (int i = 0; i < 256; i++) tick1("R4");
      chk_all("R4");

      // R6 write-one-to-clear
      wr(8'h14, 32'h5); m_evt = m_evt & ~(4'h5 & m_evt);
      chk_all("R6");
      wr(8'h14, 32'h5);
      chk_all("R6");
      wr(8'h14, 32'hF); m_evt = '0;
      chk_all("R6");

      // R5 disabled channels record nothing
      wr(8'h1C, 32'h5); m_ien = 12'h005;
      for (int i = 0; i < 256; i++) tick1("R5");
      chk_all("R5");

      // R3 counter load, load beats tick, load never matches
      wr(8'h10, 32'hF0); m_cnt = 8'hF0;
      rd_chk(8'h10, 32'hF0, "R3");
      tick1("R3");
      tick_en = 1'b1;
      wr(8'h10, 32'h20); m_cnt = 8'h20;
      tick_en = 1'b0;
      rd_chk(8'h10, 32'h20, "R3");
      wr(8'h14, 32'hF); m_evt = '0;
      wr(8'h10, 32'hFF); m_cnt = 8'hFF;
      rd_chk(8'h14, 32'h0, "R3");

      // R9 rewrite a match while counting
      wr(8'h00, 32'h03); m_mat[0] = 8'h03;
      for (int i = 0; i < 4; i++) tick1("R9");
      rd_chk(8'h14, 32'h1, "R9");
      rd_chk(8'h00, 32'h03, "R9");

      // R8 watchdog fires once with interrupts disabled
      wr(8'h1C, 32'h0); m_ien = '0;
      wr(8'h18, 32'h1); m_wd = 1'b1;
      rd_chk(8'h18, 32'h1, "R8");
      wr(8'h0C, 32'(m_cnt + 8'd2)); m_mat[3] = m_cnt + 8'd2;
      tick1("R8");
      tick1("R8");
      rd_chk(8'h18, 32'h0, "R8");
      @(negedge clk);
      chk("R8 single cycle", 32'(reset_req_o), 32'd0);
      for (int i = 0; i < 256; i++) tick1("R8");
      chk_all("R8");

      // R10 unmapped and misaligned accesses
      rd_chk(8'h20, 32'h0, "R10");
      rd_chk(8'h24, 32'h0, "R10");
      rd_chk(8'h12, 32'h0, "R10");
      rd_chk(8'hFC, 32'h0, "R10");
      wr(8'h20, 32'hFFFF_FFFF);
      wr(8'h11, 32'hFFFF_FFFF);
      wr(8'h16, 32'hFFFF_FFFF);
      wr(8'hFC, 32'hFFFF_FFFF);
      chk_all("R10");

      // R11 no read strobe gives zero data
      bus_addr = 8'h00; bus_rd = 1'b0;
      #1;
      chk("R11", bus_rdata, 32'h0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule